// File: doc/BRIEF.md
# Saturating SIMD Lane Narrowing Unit

This unit narrows two 128-bit vectors of packed signed integers into one 128-bit vector. Every source lane is halved in width. A lane whose value does not fit the narrower type is clamped to the nearest limit of that type, not cut down to its low bits. Two lane widths are supported: 32-bit lanes can be narrowed to 16 bits, and 16-bit lanes can be narrowed to 8 bits. For each operation the caller also picks a signed or an unsigned target range. In the unsigned case the source lanes are still read as signed, so negative values clamp to zero.

The unit is a single registered stage with no backpressure. The caller presents an operation code and both operands while holding `in_valid` high. On the next clock edge the packed result appears on `res_data`, and `res_valid` rises in the same cycle. In cycles where `in_valid` is low the result register keeps its last value.

Top module: `simd_pack_sat`

## Requirements
- R1: While reset is active and after its release, `res_valid` is 0 and `res_data` is all zeros until the first accepted operation.
- R2: `res_valid` is high in exactly the cycle that follows a cycle with `in_valid` high, so the latency is one clock.
- R3: `in_op` bit 0 selects the source lane width: 0 means 32-bit lanes narrowed to 16 bits, and 1 means 16-bit lanes narrowed to 8 bits. `in_op` bit 1 selects the target range: 0 is signed and 1 is unsigned.
- R4: The narrowed lanes of `src_a` fill the lower 64 result bits, with source lane i placed at narrow lane i. The narrowed lanes of `src_b` fill the upper 64 bits in the same order.
- R5: In signed 32-to-16 mode, values above 32767 become 16'h7FFF and values below -32768 become 16'h8000.
- R6: In signed 16-to-8 mode, values above 127 become 8'h7F and values below -128 become 8'h80.
- R7: In unsigned mode, any negative source lane becomes zero.
- R8: In unsigned mode, a source lane above the narrow maximum (65535 or 255) becomes all ones of the narrow width.
- R9: A source lane whose value lies inside the selected target range passes through as its low half unchanged.
- R10: When `in_valid` is low, `res_data` holds its previous value, whatever the operands and the operation code are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request in this cycle |
| in_op | input | 2 | Bit 0: lane width select, bit 1: unsigned target |
| src_a | input | 128 | First operand, fills the lower result half |
| src_b | input | 128 | Second operand, fills the upper result half |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_data | output | 128 | Packed, saturated result |

## Verification
The bound checker watches a few properties on every cycle: the one-cycle valid timing, that the result holds while idle, and the clamp values of the lowest narrow lane of each operand for out-of-range signed, negative and over-range inputs. The lane ordering, the exact pass-through of in-range values across all sixteen or eight lanes, and the reset contents can only be shown by the bench. It compares every lane against a behavioural clamp model, using boundary values just inside and just outside each range, together with random operands in all four modes.

// File: rtl/simd_pack_pkg.sv
package simd_pack_pkg;

    localparam int VEC_W  = 128;
    localparam int WIDE_W = 32;
    localparam int MID_W  = 16;

    typedef enum logic [1:0] {
        OP_SGN_W32 = 2'b00,
        OP_SGN_W16 = 2'b01,
        OP_UNS_W32 = 2'b10,
        OP_UNS_W16 = 2'b11
    } pack_op_e;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } pack_state_t;

endpackage

// File: rtl/lane_sat.sv
module lane_sat #(
    parameter int IN_W  = 32,
    parameter int OUT_W = IN_W / 2
) (
    input  logic [IN_W-1:0]  din,
    input  logic             uns,
    output logic [OUT_W-1:0] dout
);

    localparam logic [OUT_W-1:0] ALL_ONES = {OUT_W{1'b1}};
    localparam logic [OUT_W-1:0] SGN_MAX  = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] SGN_MIN  = {1'b1, {(OUT_W-1){1'b0}}};

    logic                neg;
    logic [IN_W-OUT_W:0] top_bits;
    logic                fits_sgn;
    logic                over_uns;

    always_comb begin
        neg      = din[IN_W-1];
        top_bits = din[IN_W-1:OUT_W-1];
        fits_sgn = (&top_bits) | ~(|top_bits);
        over_uns = |din[IN_W-2:OUT_W];
        if (uns) begin
            if (neg)           dout = '0;
            else if (over_uns) dout = ALL_ONES;
            else               dout = din[OUT_W-1:0];
        end else begin
            if (fits_sgn)      dout = din[OUT_W-1:0];
            else if (neg)      dout = SGN_MIN;
            else               dout = SGN_MAX;
        end
    end

endmodule

// File: rtl/narrow_vec.sv
module narrow_vec #(
    parameter int VEC_W = 128,
    parameter int IN_W  = 32
) (
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  logic             uns,
    output logic [VEC_W-1:0] packed_out
);

    localparam int OUT_W = IN_W / 2;
    localparam int LANES = VEC_W / IN_W;
    localparam int HALF  = VEC_W / 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat_a (
            .din  (opa[i*IN_W +: IN_W]),
            .uns  (uns),
            .dout (packed_out[i*OUT_W +: OUT_W])
        );
        lane_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat_b (
            .din  (opb[i*IN_W +: IN_W]),
            .uns  (uns),
            .dout (packed_out[HALF + i*OUT_W +: OUT_W])
        );
    end

endmodule

// File: rtl/simd_pack_sat.sv
module simd_pack_sat
    import simd_pack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             res_valid,
    output logic [VEC_W-1:0] res_data
);

    logic [VEC_W-1:0] nar_wide;
    logic [VEC_W-1:0] nar_mid;
    pack_state_t      st_d;
    pack_state_t      st_q;

    narrow_vec #(.VEC_W(VEC_W), .IN_W(WIDE_W)) u_nar_wide (
        .opa        (src_a),
        .opb        (src_b),
        .uns        (in_op[1]),
        .packed_out (nar_wide)
    );

    narrow_vec #(.VEC_W(VEC_W), .IN_W(MID_W)) u_nar_mid (
        .opa        (src_a),
        .opb        (src_b),
        .uns        (in_op[1]),
        .packed_out (nar_mid)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = in_op[0] ? nar_mid : nar_wide;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign res_data  = st_q.data;

endmodule

// File: rtl/simd_pack_chk.sv
module simd_pack_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   in_op,
    input logic [127:0] src_a,
    input logic [127:0] src_b,
    input logic         res_valid,
    input logic [127:0] res_data
);

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_data));

    p_sgn_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00 && !((&src_a[31:15]) || !(|src_a[31:15])))
        |=> (res_data[15:0] == 16'h8000 || res_data[15:0] == 16'h7fff));

    p_sgn_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b01 && !((&src_a[15:7]) || !(|src_a[15:7])))
        |=> (res_data[7:0] == 8'h80 || res_data[7:0] == 8'h7f));

    p_uns_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b10 && src_a[31]) |=> (res_data[15:0] == 16'h0000));

    p_uns_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b11 && !src_b[15] && (|src_b[14:8]))
        |=> (res_data[71:64] == 8'hff));

endmodule

bind simd_pack_sat simd_pack_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .src_a     (src_a),
    .src_b     (src_b),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/simd_pack_sat_tb.sv
module simd_pack_sat_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_op = 2'b00;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         res_valid;
    logic [127:0] res_data;

    int checks = 0;
    int errors = 0;
    logic [127:0] exp_data = '0;

    always #10 clk = ~clk;

    simd_pack_sat u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_data(res_data)
    );

    // Behavioural model: read each lane as a signed integer, clamp to range, place.
    function automatic logic [127:0] ref_pack(input logic [1:0] op,
                                              input logic [127:0] a,
                                              input logic [127:0] b);
        logic [127:0] r = '0;
        int  inw  = op[0] ? 16 : 32;
        int  outw = inw / 2;
        int  lanes = 128 / inw;
        longint lo = op[1] ? 0 : -(longint'(1) << (outw - 1));
        longint hi = op[1] ? (longint'(1) << outw) - 1 : (longint'(1) << (outw - 1)) - 1;
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < lanes; i++) begin
                longint v = 0;
                for (int k = 0; k < inw; k++) v[k] = (s == 0) ? a[i*inw + k] : b[i*inw + k];
                if (v[inw-1]) v = v - (longint'(1) << inw);
                if (v < lo) v = lo;
                if (v > hi) v = hi;
                for (int k = 0; k < outw; k++) r[s*64 + i*outw + k] = v[k];
            end
        end
        return r;
    endfunction

    function automatic logic [127:0] mk(input int w, input int vals[8]);
        logic [127:0] r = '0;
        for (int i = 0; i < 128 / w; i++)
            for (int k = 0; k < w; k++) r[i*w + k] = vals[i][k];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge.
    task automatic step(input bit v, input logic [1:0] op,
                        input logic [127:0] a, input logic [127:0] b, input string tag);
        in_valid = v; in_op = op; src_a = a; src_b = b;
        if (v) exp_data = ref_pack(op, a, b);
        @(negedge clk);
        check(res_valid == v, tag, "res_valid", 128'(res_valid), 128'(v));
        check(res_data == exp_data, tag, "res_data", res_data, exp_data);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v32b[8];
        int v16b[8];
        int v16c[8];
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1", "reset res_valid", 128'(res_valid), '0);
        check(res_data == '0, "R1", "reset res_data", res_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0 && res_data == '0, "R1", "after reset", res_data, '0);

        // R4 R9: in-range values keep their place, all four op codes (R3)
        v32b = '{1, 2, 3, 4, 0, 0, 0, 0};
        v16b = '{5, 6, 7, 8, 9, 10, 11, 12};
        step(1, 2'b00, mk(32, v32b), mk(32, '{-1, -2, 100, 200, 0, 0, 0, 0}), "R4");
        step(1, 2'b01, mk(16, v16b), mk(16, '{-3, 127, -128, 0, 1, 2, 3, 4}), "R9");
        step(1, 2'b10, mk(32, '{65535, 0, 4660, 1, 0, 0, 0, 0}), mk(32, v32b), "R3");
        step(1, 2'b11, mk(16, '{255, 0, 17, 200, 1, 2, 3, 4}), mk(16, v16b), "R3");

        // R5: signed 32->16 boundaries
        step(1, 2'b00, mk(32, '{32767, 32768, -32768, -32769, 0, 0, 0, 0}),
                       mk(32, '{2147483647, -2147483647 - 1, 65536, -65536, 0, 0, 0, 0}), "R5");
        // R6: signed 16->8 boundaries
        v16c = '{127, 128, -128, -129, 32767, -32768, 256, -1};
        step(1, 2'b01, mk(16, v16c), mk(16, '{200, -200, 0, 1, -1, 127, 128, -129}), "R6");
        // R7: unsigned negatives
        step(1, 2'b10, mk(32, '{-1, -32768, -2147483647 - 1, -65536, 0, 0, 0, 0}),
                       mk(32, '{-5, 0, 3, -70000, 0, 0, 0, 0}), "R7");
        step(1, 2'b11, mk(16, v16c), mk(16, '{-1, -255, -256, 0, 0, 0, 0, 0}), "R7");
        // R8: unsigned over-range
        step(1, 2'b10, mk(32, '{65535, 65536, 2147483647, 100000, 0, 0, 0, 0}),
                       mk(32, '{65534, 70000, 1, 0, 0, 0, 0, 0}), "R8");
        step(1, 2'b11, mk(16, '{255, 256, 32767, 1000, 254, 0, 300, 511}), mk(16, v16c), "R8");

        // R10 R2: idle cycles with changing operands keep the result
        step(0, 2'b01, {4{32'hdead_beef}}, {4{32'h1234_5678}}, "R10");
        step(0, 2'b10, '1, '0, "R10");
        step(1, 2'b00, {4{32'h0000_7fff}}, {4{32'hffff_8000}}, "R2");
        step(0, 2'b11, '0, '1, "R2");

        // R4 R5 R6 R7 R8: random operands, some biased near the narrow range
        for (int n = 0; n < 400; n++) begin
            logic [127:0] a, b;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            if (n % 3 == 1) begin
                a = a & {16{8'h81}};
                b = b ^ {8{16'hff00}};
            end
            step(($urandom % 4) != 0, 2'($urandom), a, b, "R4");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule